// File: doc/BRIEF.md
# UART Channel FIFO Depth and Mode Controller

This block is the configuration and buffering core of one UART channel. A host reaches it through an 8-byte register window with separate write and read strobes. A strap input also feeds it. From the FIFO-control, line-control and enhanced-feature settings and the strap, it picks one of five operating modes and the capacity that goes with that mode: 1, 16 or 128 bytes. A transmit FIFO and a receive FIFO, each one byte wide, hold exactly that many entries.

The host pushes transmit bytes by writing offset 0 and pops receive bytes by reading offset 0. The serializer side pops transmit bytes and pushes receive bytes through dedicated strobes. Each time the capacity changes, or the FIFO enable bit toggles, both FIFOs are emptied, so stored data never exceeds the new capacity. Every channel instance resets to the same state and is then programmed on its own.

Top module: `uart_fifo_mode_ctrl`

## Requirements
- R1: After reset the line-control value is 0x00, the FIFO enable, depth-extension and enhanced bits are 0, mode_code is 0, fifo_depth is 1, both FIFOs are empty and legacy750_en is 0.
- R2: While the FIFO enable bit (bit 0 of a write to offset 2) is 0, mode_code is 0 and fifo_depth is 1, whatever the strap, depth-extension and enhanced bits are.
- R3: With enable 1, enhanced 0, depth-extension 0 and strap low, mode_code is 1 and fifo_depth is 16.
- R4: With enable 1, enhanced 0 and strap high, mode_code is 2 and fifo_depth is 128.
- R5: With enable 1, enhanced 0, strap low and depth-extension 1, mode_code is 4 and fifo_depth is 128. legacy750_en is 1 exactly in this mode.
- R6: Bit 5 of an offset-2 write updates the depth-extension bit only while bit 7 of the line-control value is 1. Otherwise that bit keeps its value.
- R7: While the line-control value equals 0xBF, offset 2 is the enhanced-feature register: bit 4 of a write sets the enhanced bit, and a read returns that bit in bit 4. With enable 1 and enhanced 1, mode_code is 3 and fifo_depth is 128 for either strap level.
- R8: A FIFO flags full when its count equals fifo_depth. A push while full is dropped, a pop while empty does nothing, and data leave in arrival order. A read of offset 0 returns the receive head, or 0 when that FIFO is empty.
- R9: A change of fifo_depth, or a change of the enable bit, empties both FIFOs on the same clock edge. Outside the 0xBF window, an offset-2 write with bit 1 set empties the receive FIFO and one with bit 2 set empties the transmit FIFO.
- R10: Offset 3 reads and writes the line-control value. Offset 5 reads bit0 = receive not empty, bit1 = receive full, bit5 = transmit not full, bit6 = transmit empty, bit7 = transmit full, with all other bits 0. Offset 2 outside the 0xBF window reads the enable bit in bits 7 and 6. Offsets 1, 4, 6 and 7 read 0.
- R11: The strap is registered once per clock. A strap change reaches mode_code and fifo_depth one edge after it is applied, and that update counts as a depth change under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_sel | input | 1 | Depth strap, high selects deep FIFOs in non-enhanced mode |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Register read strobe, pops receive FIFO at offset 0 |
| bus_rdata | output | 8 | Read data for the current offset |
| ser_tx_pop | input | 1 | Serializer takes the transmit head |
| ser_tx_data | output | 8 | Transmit head, 0 when empty |
| ser_rx_push | input | 1 | Serializer delivers a receive byte |
| ser_rx_data | input | 8 | Received byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO holds fifo_depth bytes |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO holds fifo_depth bytes |
| mode_code | output | 3 | 0 byte, 1 standard, 2 strap-deep, 3 enhanced, 4 legacy-deep |
| fifo_depth | output | 8 | Effective FIFO capacity |
| legacy750_en | output | 1 | Legacy-deep features available |

## Verification
The assertions take for granted that bus_rd and bus_wr are never high together, and that the strap is a quasi-static level sampled on clk. They also rely on the serializer strobes being synchronous single-cycle pulses. The stimulus drives at most one bus strobe in each cycle and changes fifo_sel only on a falling edge. It does raise a serializer strobe together with a bus access, so that simultaneous push and pop on one FIFO are exercised.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

  typedef enum logic [2:0] {
    MODE_BYTE        = 3'd0,
    MODE_STD         = 3'd1,
    MODE_STRAP_DEEP  = 3'd2,
    MODE_ENH         = 3'd3,
    MODE_LEGACY_DEEP = 3'd4
  } fifo_mode_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_LINE = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd5;
  localparam logic [7:0] LCR_KEY  = 8'hBF;

  typedef struct packed {
    logic [7:0] lcr;
    logic       fifo_en;
    logic       deep;
    logic       enh;
  } chan_cfg_t;

  // precedence: enable, then enhanced, then strap, then extension bit
  function automatic fifo_mode_e mode_of(logic fifo_en, logic enh,
                                         logic strap, logic deep);
    if (!fifo_en) return MODE_BYTE;
    if (enh)      return MODE_ENH;
    if (strap)    return MODE_STRAP_DEEP;
    if (deep)     return MODE_LEGACY_DEEP;
    return MODE_STD;
  endfunction

  function automatic int depth_of(fifo_mode_e m, int mid, int max);
    case (m)
      MODE_BYTE: return 1;
      MODE_STD:  return mid;
      default:   return max;
    endcase
  endfunction

endpackage

// File: rtl/uart_mode_decode.sv
module uart_mode_decode
  import uart_mode_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MID_DEPTH = 16,
  parameter int MAX_DEPTH = 128
) (
  input  logic             fifo_en,
  input  logic             enh,
  input  logic             strap,
  input  logic             deep,
  output fifo_mode_e       mode,
  output logic [CNT_W-1:0] depth
);
  assign mode  = mode_of(fifo_en, enh, strap, deep);
  assign depth = CNT_W'(depth_of(mode, MID_DEPTH, MAX_DEPTH));
endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_mode_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strap_in,
  output chan_cfg_t         cfg_q,
  output chan_cfg_t         cfg_nxt,
  output logic              strap_q,
  output logic              clr_rx,
  output logic              clr_tx
);
  logic ctrl_wr, line_wr;

  assign ctrl_wr = wr && (addr == ADDR_W'(OFS_CTRL));
  assign line_wr = wr && (addr == ADDR_W'(OFS_LINE));

  always_comb begin
    cfg_nxt = cfg_q;
    clr_rx  = 1'b0;
    clr_tx  = 1'b0;
    if (ctrl_wr) begin
      if (cfg_q.lcr == LCR_KEY) begin
        cfg_nxt.enh = wdata[4];
      end else begin
        cfg_nxt.fifo_en = wdata[0];
        if (cfg_q.lcr[7]) cfg_nxt.deep = wdata[5];
        clr_rx = wdata[1];
        clr_tx = wdata[2];
      end
    end
    if (line_wr) cfg_nxt.lcr = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      strap_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_nxt;
      strap_q <= strap_in;
    end
  end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 128,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CNT_W-1:0]  limit,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MAX_DEPTH - 1);

  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign full    = (count >= limit);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_mode_ctrl.sv
module uart_fifo_mode_ctrl
  import uart_mode_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int MID_DEPTH = 16,
  parameter int MAX_DEPTH = 128,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ser_tx_pop,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              ser_rx_push,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [2:0]        mode_code,
  output logic [CNT_W-1:0]  fifo_depth,
  output logic              legacy750_en
);
  chan_cfg_t        cfg_q, cfg_nxt;
  logic             strap_q, clr_rx, clr_tx;
  fifo_mode_e       mode_cur, mode_nxt;
  logic [CNT_W-1:0] depth_cur, depth_nxt;
  logic             flush_all, tx_flush, rx_flush;
  logic             thr_wr, rbr_rd;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;

  uart_mode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .strap_in(fifo_sel),
    .cfg_q(cfg_q), .cfg_nxt(cfg_nxt), .strap_q(strap_q),
    .clr_rx(clr_rx), .clr_tx(clr_tx)
  );

  uart_mode_decode #(.CNT_W(CNT_W), .MID_DEPTH(MID_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_dec_cur (
    .fifo_en(cfg_q.fifo_en), .enh(cfg_q.enh), .strap(strap_q), .deep(cfg_q.deep),
    .mode(mode_cur), .depth(depth_cur)
  );

  uart_mode_decode #(.CNT_W(CNT_W), .MID_DEPTH(MID_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_dec_nxt (
    .fifo_en(cfg_nxt.fifo_en), .enh(cfg_nxt.enh), .strap(fifo_sel), .deep(cfg_nxt.deep),
    .mode(mode_nxt), .depth(depth_nxt)
  );

  assign flush_all = (depth_nxt != depth_cur) || (cfg_nxt.fifo_en != cfg_q.fifo_en);
  assign tx_flush  = flush_all || clr_tx;
  assign rx_flush  = flush_all || clr_rx;
  assign thr_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign rbr_rd    = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));

  uart_byte_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .limit(depth_cur),
    .push(thr_wr), .push_data(bus_wdata), .pop(ser_tx_pop),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_byte_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .limit(depth_cur),
    .push(ser_rx_push), .push_data(ser_rx_data), .pop(rbr_rd),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign mode_code    = mode_cur;
  assign fifo_depth   = depth_cur;
  assign legacy750_en = (mode_cur == MODE_LEGACY_DEEP);
  assign ser_tx_data  = tx_empty ? '0 : tx_head;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DATA): bus_rdata = rx_empty ? '0 : rx_head;
      ADDR_W'(OFS_CTRL): begin
        if (cfg_q.lcr == LCR_KEY) bus_rdata[4] = cfg_q.enh;
        else begin
          bus_rdata[7] = cfg_q.fifo_en;
          bus_rdata[6] = cfg_q.fifo_en;
        end
      end
      ADDR_W'(OFS_LINE): bus_rdata = cfg_q.lcr;
      ADDR_W'(OFS_STAT): begin
        bus_rdata[0] = !rx_empty;
        bus_rdata[1] = rx_full;
        bus_rdata[5] = !tx_full;
        bus_rdata[6] = tx_empty;
        bus_rdata[7] = tx_full;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_mode_chk.sv
module uart_mode_chk #(
  parameter int CNT_W     = 8,
  parameter int MAX_DEPTH = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             lcr7,
  input logic             deep,
  input logic             enh,
  input logic             fifo_en,
  input logic [2:0]       mode_code,
  input logic [CNT_W-1:0] fifo_depth,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             legacy750_en
);
  p_byte_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (fifo_depth == CNT_W'(1)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= fifo_depth) && (rx_count <= fifo_depth));

  p_guard_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !lcr7) |=> $stable(deep));

  p_flush_on_resize_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_depth != $past(fifo_depth)) |-> (tx_count == '0) && (rx_count == '0));

  p_legacy_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    legacy750_en |-> (mode_code == 3'd4) && (fifo_depth == CNT_W'(MAX_DEPTH)));

  p_enh_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enh && fifo_en) |-> (mode_code == 3'd3) && !legacy750_en);
endmodule

bind uart_fifo_mode_ctrl uart_mode_chk #(.CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH)) u_mode_chk (
  .clk(clk), .rst_n(rst_n),
  .ctrl_wr(bus_wr && (bus_addr == 3'd2)), .lcr7(cfg_q.lcr[7]),
  .deep(cfg_q.deep), .enh(cfg_q.enh), .fifo_en(cfg_q.fifo_en),
  .mode_code(mode_code), .fifo_depth(fifo_depth),
  .tx_count(tx_count), .rx_count(rx_count), .legacy750_en(legacy750_en)
);

// File: tb/test_uart_fifo_mode_ctrl.sv
module test_uart_fifo_mode_ctrl;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_sel = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
  logic [7:0] ser_tx_data, ser_rx_data = '0;
  logic       tx_empty, tx_full, rx_empty, rx_full, legacy750_en;
  logic [2:0] mode_code;
  logic [7:0] fifo_depth;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] m_lcr;
  bit m_en, m_deep, m_enh, m_strap;
  byte unsigned tx_q[$], rx_q[$];

  always #(CLK_NS/2) clk = ~clk;

  uart_fifo_mode_ctrl i_uart_fifo_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_rx_push(ser_rx_push),
    .ser_rx_data(ser_rx_data), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full), .mode_code(mode_code),
    .fifo_depth(fifo_depth), .legacy750_en(legacy750_en)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_mode(bit en, bit enh, bit strap, bit deep);
    int code;
    code = 1;
    if (deep) code = 4;
    if (strap) code = 2;
    if (enh) code = 3;
    if (!en) code = 0;
    return code;
  endfunction

  function automatic int m_cap(int code);
    return (code == 0) ? 1 : (code == 1) ? 16 : 128;
  endfunction

  function automatic int m_rdata(logic [2:0] a);
    int cap;
    cap = m_cap(m_mode(m_en, m_enh, m_strap, m_deep));
    case (a)
      3'd0: return (rx_q.size() > 0) ? int'(rx_q[0]) : 0;
      3'd2: return (m_lcr == 8'hBF) ? (int'(m_enh) << 4) : (m_en ? 8'hC0 : 0);
      3'd3: return int'(m_lcr);
      3'd5: return ((tx_q.size() == cap) ? 128 : 0) + ((tx_q.size() == 0) ? 64 : 0) +
                   ((tx_q.size() < cap) ? 32 : 0) + ((rx_q.size() == cap) ? 2 : 0) +
                   ((rx_q.size() > 0) ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_lcr = '0; m_en = 0; m_deep = 0; m_enh = 0; m_strap = 0;
    tx_q.delete(); rx_q.delete();
  endtask

  task automatic m_step(bit w, bit r, logic [2:0] a, logic [7:0] d, bit tp, bit rp, logic [7:0] rd);
    bit n_en, n_deep, n_enh, c_rx, c_tx, t_in, t_out, r_in, r_out;
    logic [7:0] n_lcr;
    int old_cap, new_cap;
    n_en = m_en; n_deep = m_deep; n_enh = m_enh; n_lcr = m_lcr; c_rx = 0; c_tx = 0;
    if (w && a == 3'd2) begin
      if (m_lcr == 8'hBF) n_enh = d[4];
      else begin
        n_en = d[0]; c_rx = d[1]; c_tx = d[2];
        if (m_lcr[7]) n_deep = d[5];
      end
    end
    if (w && a == 3'd3) n_lcr = d;
    old_cap = m_cap(m_mode(m_en, m_enh, m_strap, m_deep));
    new_cap = m_cap(m_mode(n_en, n_enh, fifo_sel, n_deep));
    if (old_cap != new_cap || n_en != m_en) begin
      tx_q.delete(); rx_q.delete();
    end else begin
      t_in  = w && a == 3'd0 && tx_q.size() < old_cap;
      t_out = tp && tx_q.size() > 0;
      r_in  = rp && rx_q.size() < old_cap;
      r_out = r && a == 3'd0 && rx_q.size() > 0;
      if (c_tx) tx_q.delete();
      else begin
        if (t_out) void'(tx_q.pop_front());
        if (t_in) tx_q.push_back(d);
      end
      if (c_rx) rx_q.delete();
      else begin
        if (r_out) void'(rx_q.pop_front());
        if (r_in) rx_q.push_back(rd);
      end
    end
    m_en = n_en; m_deep = n_deep; m_enh = n_enh; m_lcr = n_lcr; m_strap = fifo_sel;
  endtask

  task automatic compare_outputs();
    int code, cap;
    code = m_mode(m_en, m_enh, m_strap, m_deep);
    cap  = m_cap(code);
    chk("R2/R3/R4/R5/R7 mode_code", int'(mode_code), code);
    chk("R2/R3/R4/R5/R7 fifo_depth", int'(fifo_depth), cap);
    chk("R5 legacy750_en", int'(legacy750_en), int'(code == 4));
    chk("R8 tx_empty", int'(tx_empty), int'(tx_q.size() == 0));
    chk("R8 tx_full", int'(tx_full), int'(tx_q.size() == cap));
    chk("R8 rx_empty", int'(rx_empty), int'(rx_q.size() == 0));
    chk("R8 rx_full", int'(rx_full), int'(rx_q.size() == cap));
    chk("R8 ser_tx_data", int'(ser_tx_data), (tx_q.size() > 0) ? int'(tx_q[0]) : 0);
  endtask

  // one clock: drive on falling edge, check read data before the edge, state after it
  task automatic cyc(bit w, bit r, logic [2:0] a, logic [7:0] d, bit tp, bit rp, logic [7:0] rd);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    ser_tx_pop = tp; ser_rx_push = rp; ser_rx_data = rd;
    #1;
    chk("R10/R8 bus_rdata", int'(bus_rdata), m_rdata(a));
    @(posedge clk);
    m_step(w, r, a, d, tp, rp, rd);
    #1;
    compare_outputs();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d); cyc(1, 0, a, d, 0, 0, 8'h00); endtask
  task automatic rd(logic [2:0] a);                cyc(0, 1, a, 8'h00, 0, 0, 8'h00); endtask
  task automatic idle();                           cyc(0, 0, 3'd0, 8'h00, 0, 0, 8'h00); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state at the ports
    chk("R1 mode_code", int'(mode_code), 0);
    chk("R1 fifo_depth", int'(fifo_depth), 1);
    chk("R1 tx_empty", int'(tx_empty), 1);
    chk("R1 rx_empty", int'(rx_empty), 1);
    chk("R1 legacy750_en", int'(legacy750_en), 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    rd(3'd3);                                // R1 line control reads 0
    chk("R1 lcr readback", int'(bus_rdata), 0);

    // R2: byte mode ignores extension and enhanced bits
    wr(3'd3, 8'hBF); wr(3'd2, 8'h10);        // R7 enhanced bit via key window
    rd(3'd2);
    wr(3'd3, 8'h80); wr(3'd2, 8'h20);        // extension set, enable still 0
    chk("R2 mode byte", int'(mode_code), 0);
    chk("R2 depth one", int'(fifo_depth), 1);
    wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);        // R8 second byte dropped
    chk("R8 byte full", int'(tx_full), 1);
    cyc(0, 0, 3'd0, 8'h00, 1, 0, 8'h00);
    chk("R8 byte pop empties", int'(tx_empty), 1);

    // R7: enhanced wins over extension
    wr(3'd3, 8'h00); wr(3'd2, 8'h01);
    chk("R7 enhanced mode", int'(mode_code), 3);
    chk("R7 enhanced depth", int'(fifo_depth), 128);

    // R5: drop enhanced, extension still set
    wr(3'd3, 8'hBF); wr(3'd2, 8'h00); wr(3'd3, 8'h03);
    chk("R5 legacy deep mode", int'(mode_code), 4);
    chk("R5 legacy feature flag", int'(legacy750_en), 1);

    // R6: guarded bit unchanged while line bit 7 is 0
    wr(3'd2, 8'h01);
    chk("R6 guard keeps extension", int'(mode_code), 4);
    wr(3'd3, 8'h80); wr(3'd2, 8'h01); wr(3'd3, 8'h03);
    chk("R3 standard mode", int'(mode_code), 1);
    chk("R3 standard depth", int'(fifo_depth), 16);

    // R8: fill transmit past 16, drain in order
    for (int i = 0; i < 20; i++) wr(3'd0, 8'(8'h30 + i));
    chk("R8 tx full at 16", int'(tx_full), 1);
    for (int i = 0; i < 18; i++) cyc(0, 0, 3'd0, 8'h00, 1, 0, 8'h00);
    for (int i = 0; i < 17; i++) cyc(0, 0, 3'd0, 8'h00, 0, 1, 8'(8'h60 + i));
    chk("R8 rx full at 16", int'(rx_full), 1);
    rd(3'd5);                                 // R10 status layout
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'd0, 8'h00, 0, 1, 8'(8'h90 + i));
    for (int i = 0; i < 4; i++) rd(3'd0);

    // R9: clear bits
    wr(3'd0, 8'h11); wr(3'd2, 8'h05);
    chk("R9 tx clear", int'(tx_empty), 1);
    chk("R9 rx kept", int'(rx_empty), 0);
    wr(3'd2, 8'h03);
    chk("R9 rx clear", int'(rx_empty), 1);

    // R11 + R4: strap change resizes and flushes
    wr(3'd0, 8'h22); wr(3'd0, 8'h23);
    fifo_sel = 1;
    idle();
    chk("R4 strap deep mode", int'(mode_code), 2);
    chk("R11 strap resize flush", int'(tx_empty), 1);
    for (int i = 0; i < 130; i++) cyc(0, 0, 3'd0, 8'h00, 0, 1, 8'(i));
    chk("R8 rx full at 128", int'(rx_full), 1);
    wr(3'd3, 8'hBF); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    chk("R7 enhanced with strap high", int'(mode_code), 3);
    wr(3'd2, 8'h00);                          // R9 enable toggle flushes
    chk("R9 enable drop flush", int'(rx_empty), 1);
    for (int a = 0; a < 8; a++) rd(3'(a));    // R10 all offsets
    fifo_sel = 0;
    do_reset();
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule